// File: doc/BRIEF.md
# Two-Level Round-Robin Warp Issue Scheduler

This block picks, once per clock, which warp of a SIMD core may issue its next instruction. The core holds a fixed set of warps (16 by default), split into fetch groups of equal size (2 groups of 8 by default). For each warp, two flags come in: one says the warp has an instruction ready, and one says the warp is waiting on a long-latency memory operation. The block returns a warp index and a flag that marks the index as a valid issue.

Two policies are available and are chosen by a single configuration input. In the flat policy, one round-robin pointer covers all warps. In the two-level policy, the scheduler stays inside one active group and rotates among that group's warps. It moves to another group only after every warp of the active group is waiting on memory. The effect is that the groups reach their memory phases at different times, so the core does not go idle while all warps stall at once. The flat policy is kept as a baseline so that the two policies can be compared.

Top module: `wsched_two_level`

## Requirements
- R1: While reset is asserted, issue_valid is 0 and issue_warp is 0. The active group, every group pointer and the flat pointer return to 0.
- R2: A warp is eligible when its ready bit is 1 and its stall bit is 0. Only an eligible warp is ever issued. A ready warp whose stall bit is set is skipped until the stall bit clears.
- R3: The decision uses the inputs sampled at a rising clock edge. It appears on issue_valid and issue_warp just after that edge, and not before.
- R4: With policy_sel = 0 (flat), the issued warp is the first eligible warp found by searching upward from one past the last warp issued in flat mode, wrapping from 15 to 0.
- R5: With policy_sel = 1 (two-level), only warps of the active group are issued. Inside that group, the search starts one past the last warp issued from that group. Each group keeps its own pointer across group changes.
- R6: Warp w belongs to group w / 8, so warps 0-7 form group 0 and warps 8-15 form group 1. After reset, the active group is group 0.
- R7: In two-level mode, when every warp of the active group has its stall bit set, the next group in round-robin order that has an eligible warp becomes active. It issues in that same cycle.
- R8: In two-level mode, when the active group has no eligible warp but at least one of its warps has its stall bit clear, the group does not change and issue_valid is 0, even if another group has eligible warps.
- R9: When no warp can be issued, issue_valid is 0 and issue_warp holds its previous value.
- R10: Flat mode changes neither the active group nor the group pointers. Two-level mode does not change the flat pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| policy_sel | input | 1 | 0 = flat round-robin, 1 = two-level round-robin |
| warp_ready | input | NUM_WARPS | Per-warp instruction-ready flag |
| warp_stall | input | NUM_WARPS | Per-warp long-latency-wait flag |
| issue_valid | output | 1 | issue_warp names a warp issued this cycle |
| issue_warp | output | $clog2(NUM_WARPS) | Index of the selected warp |

## Verification
The bench targets the cases where a scheduler that only looks correct would still go wrong.

- **Partial stall in the active group.** The active group has no ready warp but is not fully stalled. A scheduler that switches groups whenever the current group is idle would issue from the other group here, instead of waiting.
- **Return to a group after a switch.** A shared pointer, or one that resets on every switch, would restart at warp 0 rather than resume where the group left off.
- **Mode interleaving.** Flat and two-level phases are mixed. Pointers that are cross-updated between modes would change the order in which warps are picked.
- **Idle cycles and stalled-but-ready warps.** The bench checks that idle cycles hold the last index and that a warp which is ready but stalled is never chosen.

// File: rtl/wsched_pkg.sv
package wsched_pkg;

    typedef enum logic {
        POLICY_FLAT      = 1'b0,
        POLICY_TWO_LEVEL = 1'b1
    } policy_e;

    // Increment with wrap to zero at lim.
    function automatic int unsigned wrap_inc(input int unsigned v, input int unsigned lim);
        return (v + 1 >= lim) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/wsched_rr_pick.sv
// Finds the first set request at or after the start index, wrapping around.
module wsched_rr_pick #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned IW    = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] req,
    input  logic [IW-1:0]    start,
    output logic             found,
    output logic [IW-1:0]    pick
);

    always_comb begin
        int unsigned pos;
        found = 1'b0;
        pick  = start;
        pos   = 0;
        for (int unsigned k = 0; k < WIDTH; k++) begin
            pos = int'(start) + k;
            if (pos >= WIDTH) pos = pos - WIDTH;
            if (!found && req[pos]) begin
                found = 1'b1;
                pick  = IW'(pos);
            end
        end
    end

endmodule

// File: rtl/wsched_grp_status.sv
// Per-group summary: any eligible warp, and every warp stalled on memory.
module wsched_grp_status #(
    parameter int unsigned NUM_WARPS  = 16,
    parameter int unsigned NUM_GROUPS = 2
) (
    input  logic [NUM_WARPS-1:0]  eligible,
    input  logic [NUM_WARPS-1:0]  stall,
    output logic [NUM_GROUPS-1:0] grp_any,
    output logic [NUM_GROUPS-1:0] grp_all_stalled
);

    localparam int unsigned GROUP_SIZE = NUM_WARPS / NUM_GROUPS;

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign grp_any[g]         = |eligible[g*GROUP_SIZE +: GROUP_SIZE];
        assign grp_all_stalled[g] = &stall[g*GROUP_SIZE +: GROUP_SIZE];
    end

endmodule

// File: rtl/wsched_two_level.sv
module wsched_two_level
    import wsched_pkg::*;
#(
    parameter int unsigned NUM_WARPS  = 16,
    parameter int unsigned NUM_GROUPS = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         policy_sel,
    input  logic [NUM_WARPS-1:0]         warp_ready,
    input  logic [NUM_WARPS-1:0]         warp_stall,
    output logic                         issue_valid,
    output logic [$clog2(NUM_WARPS)-1:0] issue_warp
);

    localparam int unsigned GROUP_SIZE = NUM_WARPS / NUM_GROUPS;
    localparam int unsigned WIW = $clog2(NUM_WARPS);
    localparam int unsigned LIW = (GROUP_SIZE > 1) ? $clog2(GROUP_SIZE) : 1;
    localparam int unsigned GIW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

    typedef struct packed {
        logic [GIW-1:0]                 grp;
        logic [NUM_GROUPS-1:0][LIW-1:0] gptr;
        logic [WIW-1:0]                 fptr;
        logic                           vld;
        logic [WIW-1:0]                 warp;
    } sched_state_t;

    sched_state_t st_d, st_q;

    logic [NUM_WARPS-1:0]           eligible;
    logic [NUM_GROUPS-1:0]          grp_any;
    logic [NUM_GROUPS-1:0]          grp_stalled;
    logic [NUM_GROUPS-1:0]          loc_found;
    logic [NUM_GROUPS-1:0][LIW-1:0] loc_pick;
    logic                           flat_found;
    logic [WIW-1:0]                 flat_pick;
    logic                           gsw_found;
    logic [GIW-1:0]                 gsw_pick;
    logic [GIW-1:0]                 gsw_start;
    logic                           cur_any;
    logic                           cur_stalled;
    policy_e                        policy;

    assign policy      = policy_e'(policy_sel);
    assign eligible    = warp_ready & ~warp_stall;
    assign cur_any     = grp_any[st_q.grp];
    assign cur_stalled = grp_stalled[st_q.grp];
    assign gsw_start   = GIW'(wrap_inc(int'(st_q.grp), NUM_GROUPS));

    wsched_grp_status #(
        .NUM_WARPS  (NUM_WARPS),
        .NUM_GROUPS (NUM_GROUPS)
    ) u_status (
        .eligible        (eligible),
        .stall           (warp_stall),
        .grp_any         (grp_any),
        .grp_all_stalled (grp_stalled)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_local
        wsched_rr_pick #(
            .WIDTH (GROUP_SIZE),
            .IW    (LIW)
        ) u_local (
            .req   (eligible[g*GROUP_SIZE +: GROUP_SIZE]),
            .start (st_q.gptr[g]),
            .found (loc_found[g]),
            .pick  (loc_pick[g])
        );
    end

    wsched_rr_pick #(
        .WIDTH (NUM_WARPS),
        .IW    (WIW)
    ) u_flat (
        .req   (eligible),
        .start (st_q.fptr),
        .found (flat_found),
        .pick  (flat_pick)
    );

    wsched_rr_pick #(
        .WIDTH (NUM_GROUPS),
        .IW    (GIW)
    ) u_grp (
        .req   (grp_any),
        .start (gsw_start),
        .found (gsw_found),
        .pick  (gsw_pick)
    );

    always_comb begin
        logic [GIW-1:0] sel_g;
        logic [LIW-1:0] sel_l;
        st_d     = st_q;
        st_d.vld = 1'b0;
        sel_g    = cur_any ? st_q.grp : gsw_pick;
        sel_l    = loc_pick[sel_g];
        if (policy == POLICY_FLAT) begin
            if (flat_found) begin
                st_d.vld  = 1'b1;
                st_d.warp = flat_pick;
                st_d.fptr = WIW'(wrap_inc(int'(flat_pick), NUM_WARPS));
            end
        end else if (cur_any || (cur_stalled && gsw_found)) begin
            st_d.vld         = 1'b1;
            st_d.grp         = sel_g;
            st_d.warp        = WIW'(int'(sel_g) * GROUP_SIZE + int'(sel_l));
            st_d.gptr[sel_g] = LIW'(wrap_inc(int'(sel_l), GROUP_SIZE));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign issue_valid = st_q.vld;
    assign issue_warp  = st_q.warp;

    AST_ISSUE_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |-> ((($past(eligible)) >> issue_warp) & NUM_WARPS'(1)) != '0); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(eligible) == '0) |-> (!issue_valid && $stable(issue_warp))); // R9

    AST_GROUP_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(policy_sel) && $past(cur_any)) |-> $stable(st_q.grp)); // R5

    AST_GROUP_MOVE_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.grp != $past(st_q.grp)) |-> $past(cur_stalled && policy_sel)); // R7

    AST_FLAT_KEEPS_GROUPS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(policy_sel) |-> ($stable(st_q.gptr) && $stable(st_q.grp))); // R10

endmodule

// File: tb/wsched_two_level_test.sv
`timescale 1ns/1ps
module wsched_two_level_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        policy_sel = 1'b0;
    logic [15:0] warp_ready = '0;
    logic [15:0] warp_stall = '0;
    logic        issue_valid;
    logic [3:0]  issue_warp;

    int n_checks = 0;
    int n_bad    = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    wsched_two_level uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .policy_sel  (policy_sel),
        .warp_ready  (warp_ready),
        .warp_stall  (warp_stall),
        .issue_valid (issue_valid),
        .issue_warp  (issue_warp)
    );

    task automatic check(input logic ev, input logic [3:0] ew, input string tag);
        n_checks++;
        if (issue_valid !== ev || issue_warp !== ew) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b warp=%0d, expected valid=%0b warp=%0d",
                     tag, issue_valid, issue_warp, ev, ew);
        end
    endtask

    // Called at a falling edge; outputs are checked at the next falling edge.
    task automatic step(input logic pol, input logic [15:0] rdy, input logic [15:0] stl,
                        input logic ev, input logic [3:0] ew, input string tag);
        policy_sel = pol;
        warp_ready = rdy;
        warp_stall = stl;
        @(negedge clk);
        check(ev, ew, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        policy_sel = 1'b0;
        warp_ready = 16'hFFFF;
        warp_stall = '0;
        @(negedge clk);
        @(negedge clk);
        check(1'b0, 4'd0, "R1");
        rst_n = 1'b1;
    endtask

    task automatic t_flat();
        do_reset();
        for (int k = 0; k < 18; k++) step(1'b0, 16'hFFFF, 16'h0000, 1'b1, 4'(k % 16), "R4");
        step(1'b0, 16'h4208, 16'h0000, 1'b1, 4'd3, "R4");
        step(1'b0, 16'h4208, 16'h0000, 1'b1, 4'd9, "R4");
        step(1'b0, 16'h4208, 16'h0000, 1'b1, 4'd14, "R4");
        step(1'b0, 16'h4208, 16'h0000, 1'b1, 4'd3, "R4");
        step(1'b0, 16'hFFFF, 16'hFFDF, 1'b1, 4'd5, "R2");
        step(1'b0, 16'hFFFF, 16'hFFDF, 1'b1, 4'd5, "R2");
        step(1'b0, 16'h0020, 16'h0020, 1'b0, 4'd5, "R2");
    endtask

    task automatic t_two_level();
        do_reset();
        policy_sel = 1'b1;
        warp_ready = 16'hFFFF;
        warp_stall = '0;
        #1 check(1'b0, 4'd0, "R3");
        @(negedge clk);
        check(1'b1, 4'd0, "R3");
        for (int k = 1; k < 10; k++) step(1'b1, 16'hFFFF, 16'h0000, 1'b1, 4'(k % 8), "R5");
        step(1'b1, 16'h0444, 16'h0000, 1'b1, 4'd2, "R6");
        step(1'b1, 16'h0444, 16'h0000, 1'b1, 4'd6, "R6");
        step(1'b1, 16'h0444, 16'h0000, 1'b1, 4'd2, "R6");
    endtask

    task automatic t_switch();
        do_reset();
        step(1'b1, 16'hFFFF, 16'h0000, 1'b1, 4'd0, "R5");
        step(1'b1, 16'hFFFF, 16'h0000, 1'b1, 4'd1, "R5");
        step(1'b1, 16'hFFFF, 16'h0000, 1'b1, 4'd2, "R5");
        step(1'b1, 16'hFFFF, 16'h00FF, 1'b1, 4'd8, "R7");
        step(1'b1, 16'hFFFF, 16'h00FF, 1'b1, 4'd9, "R7");
        step(1'b1, 16'hFFFF, 16'h0000, 1'b1, 4'd10, "R5");
        step(1'b1, 16'hFFFF, 16'hFF00, 1'b1, 4'd3, "R7");
    endtask

    task automatic t_no_switch();
        do_reset();
        step(1'b1, 16'hFF00, 16'h0000, 1'b0, 4'd0, "R8");
        step(1'b1, 16'hFF00, 16'h0000, 1'b0, 4'd0, "R8");
        step(1'b1, 16'hFF00, 16'h0000, 1'b0, 4'd0, "R8");
        step(1'b1, 16'hFF00, 16'h00FF, 1'b1, 4'd8, "R7");
        step(1'b1, 16'h00FF, 16'h0000, 1'b0, 4'd8, "R8");
        step(1'b1, 16'h00FF, 16'h0000, 1'b0, 4'd8, "R8");
    endtask

    task automatic t_idle();
        do_reset();
        step(1'b1, 16'hFFFF, 16'h0000, 1'b1, 4'd0, "R9");
        step(1'b1, 16'hFFFF, 16'h0000, 1'b1, 4'd1, "R9");
        step(1'b1, 16'h0000, 16'h0000, 1'b0, 4'd1, "R9");
        step(1'b1, 16'h0000, 16'h0000, 1'b0, 4'd1, "R9");
        step(1'b0, 16'h0000, 16'h0000, 1'b0, 4'd1, "R9");
        step(1'b0, 16'hFFFF, 16'hFFFF, 1'b0, 4'd1, "R9");
    endtask

    task automatic t_modes();
        do_reset();
        step(1'b1, 16'hFFFF, 16'h0000, 1'b1, 4'd0, "R10");
        step(1'b1, 16'hFFFF, 16'h0000, 1'b1, 4'd1, "R10");
        step(1'b1, 16'hFFFF, 16'h0000, 1'b1, 4'd2, "R10");
        step(1'b0, 16'hFFFF, 16'h0000, 1'b1, 4'd0, "R10");
        step(1'b0, 16'hFFFF, 16'h0000, 1'b1, 4'd1, "R10");
        step(1'b0, 16'hFFFF, 16'h00FF, 1'b1, 4'd8, "R10");
        step(1'b1, 16'hFFFF, 16'h0000, 1'b1, 4'd3, "R10");
    endtask

    initial begin
        t_flat();
        t_two_level();
        t_switch();
        t_no_switch();
        t_idle();
        t_modes();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: got running, expected completion");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule